// File: doc/BRIEF.md
# PCM Frame and Time-Slot Timing Generator

This block produces the complete set of framing and strobe signals for a serial PCM channel from one master clock that runs at four times the data bit rate (8.192 MHz against a 2.048 Mbit/s bit rate). A transmit counter and a receive counter each count 1024 master clocks per 125 µs frame. Their bits give the data-rate clocks, a 256 kHz clock, the frame syncs and a word sync that marks a four-frame cycle. From each counter a one-slot-wide strobe is decoded at any of 32 positions, and a 5-bit code picks the position.

The outputs fall into two groups. The data clocks and slot strobes pass through a register, so they are free of glitches and their edges line up. The 256 kHz clock and the three sync outputs come straight from counter bits, so they lead the registered group by one master clock. The receive counter either steps on every master clock and is locked to the transmit counter once per four-frame cycle, or steps on an external tick. In the external mode a push-button edge clears both counters together.

Top module: `pcm_frame_timing`

## Requirements
- R1: While `rst` is high and in the cycle after it: `tx_bclk`, `rx_bclk`, `tx_slot_stb` and `rx_slot_stb` are 0, `tx_clk256` is 0, and `tx_fsync`, `rx_fsync` and `word_sync` are 1 (both counters at zero).
- R2: `tx_bclk` and `rx_bclk` equal bit 1 of their counter as it stood one master clock earlier: a square wave with a period of 4 master clocks (2.048 MHz).
- R3: `tx_clk256` equals bit 4 of the transmit count in the same cycle, with no register: a period of 32 master clocks.
- R4: A frame is 1024 master clocks. `tx_fsync` and `rx_fsync` are high while bit 9 of their counter is 0, i.e. for the first 512 counts of each frame. They rise in the cycle in which the count returns to 0, one master clock ahead of the registered outputs.
- R5: A slot strobe is high for exactly 32 consecutive master clocks, one master clock after its counter holds a value from code×32 to code×32+31, where code is the unsigned 5-bit value on `tx_slot_code` or `rx_slot_code`. Code 31 ends on the first count of the next frame.
- R6: `word_sync` has a period of 4096 master clocks and is high during the first two frames of each four-frame cycle (bit 11 of the transmit count is 0).
- R7: With `rx_ext_sel` = 0 the receive counter steps on every master clock. In the cycle after the transmit count reaches 4095 it reads 0, so any offset between the two counters is removed within one four-frame cycle. The receive strobe position follows only `rx_slot_code`.
- R8: With `rx_ext_sel` = 1 the receive counter steps only in cycles where `rx_ext_tick` is 1 and is never cleared by the transmit counter.
- R9: With `rx_ext_sel` = 1, a rising edge on `btn_in` clears both counters so that they read 0 after the third rising master-clock edge that follows the edge. Holding `btn_in` high gives no further clear.
- R10: With `rx_ext_sel` = 0, `btn_in` has no effect: the transmit counter keeps stepping every master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, four times the data bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_ext_sel | input | 1 | 1: receive counter steps on `rx_ext_tick`; 0: on every clock |
| rx_ext_tick | input | 1 | Step enable for the receive counter in external mode |
| btn_in | input | 1 | Asynchronous push-button level, clears the counters in external mode |
| tx_slot_code | input | 5 | Transmit slot position, 0 to 31 |
| rx_slot_code | input | 5 | Receive slot position, 0 to 31 |
| tx_bclk | output | 1 | Registered transmit data clock |
| rx_bclk | output | 1 | Registered receive data clock |
| tx_slot_stb | output | 1 | Registered transmit slot strobe |
| rx_slot_stb | output | 1 | Registered receive slot strobe |
| tx_clk256 | output | 1 | Unregistered 256 kHz transmit clock |
| tx_fsync | output | 1 | Unregistered transmit frame sync |
| rx_fsync | output | 1 | Unregistered receive frame sync |
| word_sync | output | 1 | Unregistered four-frame sync |

## Verification
The unregistered outputs take their new value from the same rising edge that advances the counter. The data clocks and slot strobes take theirs from the next edge. A button edge becomes a counter clear on the third rising edge after it. The bench keeps its own transmit and receive counts, steps them once per rising edge, and keeps their values from before that edge. It then compares every output on the falling edge: unregistered outputs against the new counts, registered outputs against the previous counts. The button clear is scheduled three edges after the press, and only in external mode.

// File: rtl/pcm_timing_pkg.sv
package pcm_timing_pkg;

  // Registered signals of one direction: data clock and slot strobe.
  typedef struct packed {
    logic bclk;
    logic slot;
  } pcm_lane_t;

  localparam pcm_lane_t LANE_IDLE = '{bclk: 1'b0, slot: 1'b0};

endpackage

// File: rtl/pcm_frame_counter.sv
module pcm_frame_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pcm_lane_retimer.sv
module pcm_lane_retimer
  import pcm_timing_pkg::*;
#(
  parameter int FRAME_W = 10,
  parameter int SLOT_W  = 5,
  parameter int BIT_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] cnt,
  input  logic [SLOT_W-1:0]  slot_code,
  output pcm_lane_t          lane
);

  localparam int SLOT_MSB = FRAME_W - 1;

  logic slot_hit;

  // Slot field is the top SLOT_W bits of the frame count.
  assign slot_hit = (cnt[SLOT_MSB -: SLOT_W] == slot_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      lane <= LANE_IDLE;
    end else begin
      lane.bclk <= cnt[BIT_W-1];
      lane.slot <= slot_hit;
    end
  end

endmodule

// File: rtl/pcm_button_pulse.sv
module pcm_button_pulse #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_in,
  output logic pulse
);

  logic [SYNC_N-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], btn_in};
      last_q <= sync_q[SYNC_N-1];
    end
  end

  assign pulse = sync_q[SYNC_N-1] & ~last_q;

endmodule

// File: rtl/pcm_frame_timing.sv
module pcm_frame_timing
  import pcm_timing_pkg::*;
#(
  parameter int FRAME_W  = 10,
  parameter int MF_W     = 2,
  parameter int SLOT_W   = 5,
  parameter int BIT_W    = 2,
  parameter int CLK_LO_B = 4,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_ext_sel,
  input  logic              rx_ext_tick,
  input  logic              btn_in,
  input  logic [SLOT_W-1:0] tx_slot_code,
  input  logic [SLOT_W-1:0] rx_slot_code,
  output logic              tx_bclk,
  output logic              rx_bclk,
  output logic              tx_slot_stb,
  output logic              rx_slot_stb,
  output logic              tx_clk256,
  output logic              tx_fsync,
  output logic              rx_fsync,
  output logic              word_sync
);

  localparam int TX_W = FRAME_W + MF_W;

  logic [TX_W-1:0]    tx_cnt;
  logic [FRAME_W-1:0] rx_cnt;
  logic               btn_clr;
  logic               tx_wrap;
  logic               tx_clr;
  logic               rx_clr;
  logic               rx_adv;
  pcm_lane_t          tx_lane;
  pcm_lane_t          rx_lane;

  pcm_button_pulse #(.SYNC_N(SYNC_N)) u_btn (
    .clk    (clk),
    .rst    (rst),
    .btn_in (btn_in),
    .pulse  (btn_clr)
  );

  // Last count of the four-frame cycle.
  assign tx_wrap = &tx_cnt;

  // Button only acts when the receive side runs from the external tick.
  assign tx_clr = btn_clr & rx_ext_sel;
  assign rx_clr = rx_ext_sel ? btn_clr : tx_wrap;
  assign rx_adv = rx_ext_sel ? rx_ext_tick : 1'b1;

  pcm_frame_counter #(.W(TX_W)) u_tx_cnt (
    .clk (clk),
    .rst (rst),
    .adv (1'b1),
    .clr (tx_clr),
    .cnt (tx_cnt)
  );

  pcm_frame_counter #(.W(FRAME_W)) u_rx_cnt (
    .clk (clk),
    .rst (rst),
    .adv (rx_adv),
    .clr (rx_clr),
    .cnt (rx_cnt)
  );

  pcm_lane_retimer #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_tx_rt (
    .clk       (clk),
    .rst       (rst),
    .cnt       (tx_cnt[FRAME_W-1:0]),
    .slot_code (tx_slot_code),
    .lane      (tx_lane)
  );

  pcm_lane_retimer #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_rx_rt (
    .clk       (clk),
    .rst       (rst),
    .cnt       (rx_cnt),
    .slot_code (rx_slot_code),
    .lane      (rx_lane)
  );

  // Registered group.
  assign tx_bclk     = tx_lane.bclk;
  assign tx_slot_stb = tx_lane.slot;
  assign rx_bclk     = rx_lane.bclk;
  assign rx_slot_stb = rx_lane.slot;

  // Unregistered group: one master clock ahead of the registered group.
  assign tx_clk256 = tx_cnt[CLK_LO_B];
  assign tx_fsync  = ~tx_cnt[FRAME_W-1];
  assign rx_fsync  = ~rx_cnt[FRAME_W-1];
  assign word_sync = ~tx_cnt[TX_W-1];

endmodule

// File: rtl/pcm_frame_timing_chk.sv
module pcm_frame_timing_chk #(
  parameter int FRAME_W = 10,
  parameter int MF_W    = 2,
  parameter int SLOT_W  = 5
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      rx_ext_sel,
  input logic                      rx_ext_tick,
  input logic                      btn_clr,
  input logic [FRAME_W+MF_W-1:0]   tx_cnt,
  input logic [FRAME_W-1:0]        rx_cnt,
  input logic [SLOT_W-1:0]         tx_slot_code,
  input logic                      tx_bclk,
  input logic                      tx_slot_stb,
  input logic                      tx_fsync,
  input logic                      rx_fsync
);

  localparam int TX_W   = FRAME_W + MF_W;
  localparam int SLOT_L = 1 << (FRAME_W - SLOT_W);

  logic [TX_W-1:0]    tx_inc;
  logic [FRAME_W:0]   run_q;

  assign tx_inc = tx_cnt + 1'b1;

  // Consecutive high cycles of the transmit strobe before this one.
  always_ff @(posedge clk) begin
    if (rst || rx_ext_sel || !tx_slot_stb) begin
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assert_bclk_cadence_R2: assert property (@(posedge clk) disable iff (rst || rx_ext_sel)
    $rose(tx_bclk) |=> (tx_bclk ##1 !tx_bclk));

  assert_fsync_lead_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_fsync) && tx_slot_code == '0 && $stable(tx_slot_code)) |=> tx_slot_stb);

  assert_slot_width_R5: assert property (@(posedge clk) disable iff (rst || rx_ext_sel)
    tx_slot_stb |-> (run_q < SLOT_L));

  assert_rx_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (!rx_ext_sel && (&tx_cnt)) |=> (rx_fsync && tx_fsync));

  assert_ext_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_ext_sel && !rx_ext_tick && !btn_clr) |=> $stable(rx_cnt));

  assert_btn_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (btn_clr && rx_ext_sel) |=> (tx_cnt == '0 && rx_cnt == '0));

  assert_btn_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    !rx_ext_sel |=> (tx_cnt == $past(tx_inc)));

endmodule

bind pcm_frame_timing pcm_frame_timing_chk #(
  .FRAME_W (FRAME_W),
  .MF_W    (MF_W),
  .SLOT_W  (SLOT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rx_ext_sel   (rx_ext_sel),
  .rx_ext_tick  (rx_ext_tick),
  .btn_clr      (btn_clr),
  .tx_cnt       (tx_cnt),
  .rx_cnt       (rx_cnt),
  .tx_slot_code (tx_slot_code),
  .tx_bclk      (tx_bclk),
  .tx_slot_stb  (tx_slot_stb),
  .tx_fsync     (tx_fsync),
  .rx_fsync     (rx_fsync)
);

// File: tb/sim_pcm_frame_timing.sv
module sim_pcm_frame_timing;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_ext_sel = 1'b0;
  logic       rx_ext_tick = 1'b0;
  logic       btn_in = 1'b0;
  logic [4:0] tx_slot_code = 5'd0;
  logic [4:0] rx_slot_code = 5'd0;
  logic       tx_bclk, rx_bclk, tx_slot_stb, rx_slot_stb;
  logic       tx_clk256, tx_fsync, rx_fsync, word_sync;

  int  checks = 0;
  int  errors = 0;
  int  tk = 0, rk = 0, tkp = 0, rkp = 0;
  int  btn_due = 0;
  bit  pv = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  pcm_frame_timing u0 (
    .clk          (clk),
    .rst          (rst),
    .rx_ext_sel   (rx_ext_sel),
    .rx_ext_tick  (rx_ext_tick),
    .btn_in       (btn_in),
    .tx_slot_code (tx_slot_code),
    .rx_slot_code (rx_slot_code),
    .tx_bclk      (tx_bclk),
    .rx_bclk      (rx_bclk),
    .tx_slot_stb  (tx_slot_stb),
    .rx_slot_stb  (rx_slot_stb),
    .tx_clk256    (tx_clk256),
    .tx_fsync     (tx_fsync),
    .rx_fsync     (rx_fsync),
    .word_sync    (word_sync)
  );

  function automatic logic bit_of(int v, int b);
    return logic'((v >> b) & 1);
  endfunction

  task automatic chk(string req, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b (tx count %0d, rx count %0d)",
               req, name, act, exp, tk, rk);
    end
  endtask

  task automatic chk_int(string req, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  // One master clock: advance the bench's own counts, then compare on the falling edge.
  task automatic step(string rtag, string ttag);
    bit clr_now;
    @(posedge clk);
    tkp = tk;
    rkp = rk;
    clr_now = 1'b0;
    if (btn_due > 0) begin
      btn_due--;
      if (btn_due == 0) clr_now = 1'b1;
    end
    if (rst) begin
      tk = 0; rk = 0; pv = 1'b0;
    end else begin
      pv = 1'b1;
      if (clr_now && rx_ext_sel) begin
        tk = 0; rk = 0;
      end else begin
        tk = (tk + 1) % 4096;
        if (!rx_ext_sel && tkp == 4095) rk = 0;
        else if (!rx_ext_sel || rx_ext_tick) rk = (rk + 1) % 1024;
      end
    end
    @(negedge clk);
    chk((ttag == "") ? "R2" : ttag, "tx_bclk", tx_bclk, pv & bit_of(tkp, 1));
    chk((ttag == "") ? "R5" : ttag, "tx_slot_stb", tx_slot_stb,
        pv & logic'(((tkp % 1024) >> 5) == int'(tx_slot_code)));
    chk((ttag == "") ? "R3" : ttag, "tx_clk256", tx_clk256, bit_of(tk, 4));
    chk((ttag == "") ? "R4" : ttag, "tx_fsync", tx_fsync, ~bit_of(tk, 9));
    chk((ttag == "") ? "R6" : ttag, "word_sync", word_sync, ~bit_of(tk, 11));
    chk(rtag, "rx_bclk", rx_bclk, pv & bit_of(rkp, 1));
    chk(rtag, "rx_slot_stb", rx_slot_stb, pv & logic'((rkp >> 5) == int'(rx_slot_code)));
    chk(rtag, "rx_fsync", rx_fsync, ~bit_of(rk, 9));
  endtask

  task automatic press_button();
    btn_in = 1'b1;
    btn_due = 3;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) step("R1", "R1");
    chk("R1", "tx_fsync in reset", tx_fsync, 1'b1);
    chk("R1", "word_sync in reset", word_sync, 1'b1);
    chk("R1", "tx_slot_stb in reset", tx_slot_stb, 1'b0);
    rst = 1'b0;
    step("R1", "R1");
  endtask

  task automatic t_tx_frame();
    int highs;
    tx_slot_code = 5'd0;
    for (int i = 0; i < 4200; i++) step("R2", "");
    highs = 0;
    for (int i = 0; i < 1024; i++) begin
      step("R2", "");
      if (tx_slot_stb) highs++;
    end
    chk_int("R5", "strobe width in one frame", highs, 32);
    tx_slot_code = 5'd31;
    rx_slot_code = 5'd13;
    for (int i = 0; i < 1100; i++) step("R5", "");
  endtask

  task automatic t_rx_lock();
    rx_slot_code = 5'd7;
    rx_ext_sel = 1'b1;
    for (int i = 0; i < 150; i++) begin
      rx_ext_tick = (i % 3 == 0);
      step("R8", "");
    end
    rx_ext_tick = 1'b0;
    rx_ext_sel = 1'b0;
    while (tk != 0) step("R7", "");
    for (int i = 0; i < 64; i++) begin
      step("R7", "");
      chk("R7", "rx_fsync locked to tx_fsync", rx_fsync, tx_fsync);
    end
  endtask

  task automatic t_ext_hold();
    while (tk != 4000) step("R7", "");
    rx_ext_sel = 1'b1;
    rx_ext_tick = 1'b0;
    for (int i = 0; i < 200; i++) step("R8", "");
    chk("R8", "rx_fsync held across tx wrap", rx_fsync, 1'b0);
    chk("R8", "rx_slot_stb held", rx_slot_stb, 1'b0);
  endtask

  task automatic t_btn_ext();
    rx_ext_tick = 1'b1;
    for (int i = 0; i < 37; i++) step("R8", "");
    press_button();
    for (int i = 0; i < 3; i++) step("R9", "");
    chk("R9", "tx_fsync after clear", tx_fsync, 1'b1);
    chk("R9", "rx_fsync after clear", rx_fsync, 1'b1);
    chk("R9", "tx_clk256 after clear", tx_clk256, 1'b0);
    for (int i = 0; i < 1100; i++) begin
      step("R9", "R9");
      chk("R9", "rx_fsync equals tx_fsync", rx_fsync, tx_fsync);
    end
    btn_in = 1'b0;
    step("R9", "R9");
  endtask

  task automatic t_btn_int();
    rx_ext_sel = 1'b0;
    rx_ext_tick = 1'b0;
    for (int i = 0; i < 20; i++) step("R10", "R10");
    press_button();
    for (int i = 0; i < 40; i++) step("R10", "R10");
    btn_in = 1'b0;
    for (int i = 0; i < 10; i++) step("R10", "R10");
  endtask

  initial begin
    t_reset();
    t_tx_frame();
    t_rx_lock();
    t_ext_hold();
    t_btn_ext();
    t_btn_int();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 60000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule